// File: doc/BRIEF.md
# Codec command shifter

This block turns host register accesses into frames on a three-wire serial link to an audio codec: an active-low chip select, a serial clock and a data line. The host opens a frame by reading one of two addresses. Then it writes once to the data address for each serial bit. Each accepted write sends one bit with one generated clock pulse. A read of a third address closes the frame.

Two frame types are in use. Codec commands are 16 bits long and are opened from the command address. Typical commands are the power-up sequence A007, A240, A30D, A103 (hex), mute A38D, unmute A30D, and the clock-range words A240 (rates below 55 kHz) and A24D (55 kHz and above). Playback levels are A600 plus an 8-bit level code for the left channel and A700 plus the code for the right channel.

Capture-gain words are 32 bits long and are opened by a read of the data address. From the most significant byte down, they carry the mic level twice, then the right level, then the left level. The host drives the bit order, always most significant bit first. After each frame the block reports how many bits the frame carried.

Top module: `codec_cmd_shifter`

## Requirements
- R1: After reset, cdc_cs_n is 1, cdc_sclk is 0, cdc_sdata is 0, busy is 0, err_dropped is 0 and last_frame_bits is 0.
- R2: When no frame is open, a read strobe at ADDR_OPEN or at ADDR_DATA opens a frame. cdc_cs_n is low in the cycle after the strobe, err_dropped is cleared and the bit count of the new frame starts from zero.
- R3: A write strobe at ADDR_DATA in an open frame with busy low is accepted. Bit 7 of the written byte appears on cdc_sdata in the next cycle and holds for the whole bit. Bits 6..0 have no effect.
- R4: An accepted bit keeps busy high for 2*HALF_CYC cycles. cdc_sclk is low for the first HALF_CYC of those cycles and high for the last HALF_CYC. Both busy and cdc_sclk are low in the cycle after that.
- R5: A data write made while busy is high is dropped: cdc_sdata does not change and no clock pulse is added. The write sets err_dropped, which stays set until the next frame opens.
- R6: A read strobe at ADDR_CLOSE with no bit in flight releases cdc_cs_n high exactly 2*HALF_CYC cycles after the strobe cycle. last_frame_bits then shows the number of clock pulses in that frame.
- R7: If the close strobe arrives in the same cycle as an accepted data write, the bit is still sent in full. The one-period tail starts only after busy falls, so cdc_cs_n rises 4*HALF_CYC+1 cycles after the strobe.
- R8: When no frame is open, data writes and close reads have no effect: no clock pulse, cdc_cs_n stays high, busy stays low and last_frame_bits is unchanged.
- R9: The bits sampled on the codec side at each rising cdc_sclk equal the written word, most significant bit first. This holds for 16-bit command frames opened at ADDR_OPEN and for 32-bit gain frames opened at ADDR_DATA, and last_frame_bits reads 16 or 32 for them.
- R10: last_frame_bits saturates at MAX_BITS when a frame carries more pulses than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd_stb | input | 1 | One-cycle host read strobe |
| host_rd_addr | input | ADDR_W | Address of the read |
| host_wr_stb | input | 1 | One-cycle host write strobe |
| host_wr_addr | input | ADDR_W | Address of the write |
| host_wr_data | input | 8 | Write data; bit 7 is the serial bit |
| cdc_cs_n | output | 1 | Codec chip select, low during a frame |
| cdc_sclk | output | 1 | Codec serial clock, idles low |
| cdc_sdata | output | 1 | Codec serial data, sampled on rising cdc_sclk |
| busy | output | 1 | A bit is being shifted out |
| err_dropped | output | 1 | Sticky flag: a data write was dropped while busy |
| last_frame_bits | output | $clog2(MAX_BITS+1) | Clock pulses in the last closed frame |

## Verification
A data write and a close read can land in the same cycle, because the host read and write strobes are separate. The bench provokes this by raising both strobes on one edge while a frame is open. It passes when the bit is still shifted out with its full clock pulse and the chip select stays low until one full period after busy falls, 4*HALF_CYC+1 cycles after the strobe. The closed frame must then report exactly one bit. A second collision test sends a data write in the cycle right after an accepted one. It checks that the write is dropped, the data line keeps its value and the error flag stays set until the next frame opens.

// File: rtl/codec_shift_pkg.sv
`timescale 1ns/1ps
package codec_shift_pkg;
   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_OPEN  = 2'd1,
      FR_DRAIN = 2'd2,
      FR_TAIL  = 2'd3
   } frame_st_e;
endpackage

// File: rtl/cmd_bit_clkgen.sv
`timescale 1ns/1ps
// One bit period: data set up with the clock low, then clock high.
module cmd_bit_clkgen #(
   parameter int HALF_CYC = 2,
   parameter int DATA_BIT = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_go,
   input  logic [7:0] wr_byte,
   output logic       sclk,
   output logic       sdata,
   output logic       busy,
   output logic       bit_rise
);
   localparam int PH_W = $clog2(2 * HALF_CYC);
   localparam logic [PH_W-1:0] RISE_AT = PH_W'(HALF_CYC - 1);
   localparam logic [PH_W-1:0] END_AT  = PH_W'(2 * HALF_CYC - 1);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end
   if (DATA_BIT < 0 || DATA_BIT > 7) begin : g_bad_bit
      $error("DATA_BIT must select a bit of the byte");
   end

   logic [PH_W-1:0] ph;

   assign bit_rise = busy && (ph == RISE_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= '0;
         sclk  <= 1'b0;
         sdata <= 1'b0;
         busy  <= 1'b0;
      end else if (bit_go) begin
         ph    <= '0;
         sclk  <= 1'b0;
         sdata <= wr_byte[DATA_BIT];
         busy  <= 1'b1;
      end else if (busy) begin
         ph <= ph + 1'b1;
         if (ph == RISE_AT) sclk <= 1'b1;
         if (ph == END_AT) begin
            sclk <= 1'b0;
            busy <= 1'b0;
         end
      end
   end

   AST_SCLK_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> busy); // R4
   AST_SDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sdata)); // R3
   AST_BIT_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(sclk)); // R4
endmodule

// File: rtl/cmd_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencing: open/close decode, write gating, tail timer, bit count.
module cmd_frame_ctrl
   import codec_shift_pkg::*;
#(
   parameter int              ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] ADDR_OPEN  = 8'h38,
   parameter logic [ADDR_W-1:0] ADDR_DATA  = 8'h2C,
   parameter logic [ADDR_W-1:0] ADDR_CLOSE = 8'h28,
   parameter int              HALF_CYC   = 2,
   parameter int              MAX_BITS   = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_stb,
   input  logic [ADDR_W-1:0]              rd_addr,
   input  logic                           wr_stb,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic                           busy,
   input  logic                           bit_rise,
   output logic                           bit_go,
   output logic                           cs_n,
   output logic                           err,
   output logic [$clog2(MAX_BITS+1)-1:0]  last_bits
);
   localparam int TAIL_LEN = 2 * HALF_CYC;
   localparam int TC_W     = $clog2(TAIL_LEN);
   localparam int CNT_W    = $clog2(MAX_BITS + 1);
   localparam logic [TC_W-1:0]  TC_END  = TC_W'(TAIL_LEN - 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_BITS);

   if (MAX_BITS < 1) begin : g_bad_max
      $error("MAX_BITS must be at least 1");
   end
   if (ADDR_OPEN == ADDR_CLOSE || ADDR_DATA == ADDR_CLOSE) begin : g_bad_addr
      $error("close address must differ from the opening addresses");
   end

   frame_st_e       st;
   logic [TC_W-1:0] tc;
   logic [CNT_W-1:0] cnt;
   logic            open_hit, close_hit, data_wr;

   assign open_hit  = rd_stb && (rd_addr == ADDR_OPEN || rd_addr == ADDR_DATA);
   assign close_hit = rd_stb && (rd_addr == ADDR_CLOSE);
   assign data_wr   = wr_stb && (wr_addr == ADDR_DATA);
   assign bit_go    = (st == FR_OPEN) && data_wr && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         tc        <= '0;
         cnt       <= '0;
         cs_n      <= 1'b1;
         err       <= 1'b0;
         last_bits <= '0;
      end else begin
         if (bit_rise && cnt != CNT_TOP) cnt <= cnt + 1'b1;
         unique case (st)
            FR_IDLE: begin
               if (open_hit) begin
                  st   <= FR_OPEN;
                  cs_n <= 1'b0;
                  cnt  <= '0;
                  err  <= 1'b0;
               end
            end
            FR_OPEN: begin
               if (data_wr && busy) err <= 1'b1;
               if (close_hit) begin
                  tc <= '0;
                  st <= (busy || bit_go) ? FR_DRAIN : FR_TAIL;
               end
            end
            FR_DRAIN: begin
               if (!busy) begin
                  tc <= '0;
                  st <= FR_TAIL;
               end
            end
            FR_TAIL: begin
               tc <= tc + 1'b1;
               if (tc == TC_END) begin
                  st        <= FR_IDLE;
                  cs_n      <= 1'b1;
                  last_bits <= cnt;
               end
            end
            default: st <= FR_IDLE;
         endcase
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(st == FR_IDLE && open_hit)) |=> err); // R5
   AST_LAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      last_bits <= CNT_TOP); // R10
   AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_IDLE) |-> !bit_go); // R8
endmodule

// File: rtl/codec_cmd_shifter.sv
`timescale 1ns/1ps
module codec_cmd_shifter #(
   parameter int              ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] ADDR_OPEN  = 8'h38,
   parameter logic [ADDR_W-1:0] ADDR_DATA  = 8'h2C,
   parameter logic [ADDR_W-1:0] ADDR_CLOSE = 8'h28,
   parameter int              HALF_CYC   = 2,
   parameter int              DATA_BIT   = 7,
   parameter int              MAX_BITS   = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_rd_stb,
   input  logic [ADDR_W-1:0]             host_rd_addr,
   input  logic                          host_wr_stb,
   input  logic [ADDR_W-1:0]             host_wr_addr,
   input  logic [7:0]                    host_wr_data,
   output logic                          cdc_cs_n,
   output logic                          cdc_sclk,
   output logic                          cdc_sdata,
   output logic                          busy,
   output logic                          err_dropped,
   output logic [$clog2(MAX_BITS+1)-1:0] last_frame_bits
);
   logic bit_go, bit_rise;

   cmd_frame_ctrl #(
      .ADDR_W(ADDR_W), .ADDR_OPEN(ADDR_OPEN), .ADDR_DATA(ADDR_DATA),
      .ADDR_CLOSE(ADDR_CLOSE), .HALF_CYC(HALF_CYC), .MAX_BITS(MAX_BITS)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .rd_stb(host_rd_stb), .rd_addr(host_rd_addr),
      .wr_stb(host_wr_stb), .wr_addr(host_wr_addr),
      .busy(busy), .bit_rise(bit_rise), .bit_go(bit_go),
      .cs_n(cdc_cs_n), .err(err_dropped), .last_bits(last_frame_bits)
   );

   cmd_bit_clkgen #(
      .HALF_CYC(HALF_CYC), .DATA_BIT(DATA_BIT)
   ) u_bit (
      .clk(clk), .rst_n(rst_n), .bit_go(bit_go), .wr_byte(host_wr_data),
      .sclk(cdc_sclk), .sdata(cdc_sdata), .busy(busy), .bit_rise(bit_rise)
   );

   AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cdc_cs_n); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cdc_cs_n |-> !cdc_sclk); // R8
endmodule

// File: tb/codec_cmd_shifter_tb_top.sv
`timescale 1ns/1ps
module codec_cmd_shifter_tb_top;
   localparam int H = 2;
   localparam int MAXB = 32;
   localparam logic [7:0] A_OPEN  = 8'h38;
   localparam logic [7:0] A_DATA  = 8'h2C;
   localparam logic [7:0] A_CLOSE = 8'h28;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
   logic cs_n, sclk, sdata, busy, err;
   logic [5:0] last_bits;

   int n_chk = 0, n_bad = 0, cyc = 0, mon_cnt = 0;
   logic [63:0] mon_word = '0;

   always #2.5 clk = ~clk;

   codec_cmd_shifter #(
      .ADDR_W(8), .ADDR_OPEN(A_OPEN), .ADDR_DATA(A_DATA), .ADDR_CLOSE(A_CLOSE),
      .HALF_CYC(H), .DATA_BIT(7), .MAX_BITS(MAXB)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_rd_stb(rd_stb), .host_rd_addr(rd_addr),
      .host_wr_stb(wr_stb), .host_wr_addr(wr_addr), .host_wr_data(wr_data),
      .cdc_cs_n(cs_n), .cdc_sclk(sclk), .cdc_sdata(sdata),
      .busy(busy), .err_dropped(err), .last_frame_bits(last_bits)
   );

   // codec-side sampler
   always @(posedge sclk) begin
      mon_word <= {mon_word[62:0], sdata};
      mon_cnt  <= mon_cnt + 1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [7:0] a);
      @(negedge clk); rd_stb = 1'b1; rd_addr = a;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_addr = A_DATA; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic wait_idle_bit();
      while (busy) @(negedge clk);
   endtask

   task automatic count_to_cs_high(output int j);
      j = 0;
      while (cs_n == 1'b0 && j < 200) begin @(negedge clk); j++; end
   endtask

   task automatic t_reset();
      chk(cs_n == 1 && sclk == 0 && sdata == 0, "R1 pins", {cs_n, sclk, sdata}, 3'b100);
      chk(busy == 0 && err == 0 && last_bits == 0, "R1 state",
          {busy, err, last_bits}, 0);
   endtask

   task automatic send_frame(input logic [7:0] oa, input logic [63:0] w,
                             input int n, input string tag);
      int c0, j;
      logic [63:0] m;
      c0 = mon_cnt;
      do_read(oa);
      chk(cs_n == 0, {tag, " R2 open"}, cs_n, 0);
      for (int i = n - 1; i >= 0; i--) begin
         do_write({w[i], 7'(i * 37) ^ {7{~w[i]}}});   // R3 low bits vary
         wait_idle_bit();
      end
      do_read(A_CLOSE);
      count_to_cs_high(j);
      chk(j == 2 * H, {tag, " R6 tail"}, j, 2 * H);
      chk(last_bits == 6'(n > MAXB ? MAXB : n), {tag, " R6 R9 R10 count"},
          last_bits, n > MAXB ? MAXB : n);
      chk(mon_cnt - c0 == n, {tag, " R9 pulses"}, mon_cnt - c0, n);
      m = (n >= 64) ? '1 : ((64'd1 << n) - 1);
      chk((mon_word & m) == (w & m), {tag, " R9 data"}, mon_word & m, w & m);
   endtask

   task automatic t_bit_shape();
      logic exp_s;
      do_read(A_OPEN);
      do_write(8'h80);
      for (int j = 0; j <= 2 * H; j++) begin
         exp_s = (j >= H && j < 2 * H);
         chk(sclk == exp_s && busy == (j < 2 * H), "R4 shape",
             {sclk, busy}, {exp_s, (j < 2 * H)});
         if (j < 2 * H) chk(sdata == 1, "R3 hold", sdata, 1);
         @(negedge clk);
      end
      do_read(A_CLOSE);
      wait (cs_n == 1'b1);
   endtask

   task automatic t_drop();
      int j;
      do_read(A_OPEN);
      do_write(8'h80);
      do_write(8'h7F);
      chk(err == 1, "R5 err set", err, 1);
      chk(sdata == 1, "R5 sdata kept", sdata, 1);
      wait_idle_bit();
      do_read(A_CLOSE);
      count_to_cs_high(j);
      chk(last_bits == 1, "R5 one pulse", last_bits, 1);
      chk(err == 1, "R5 sticky", err, 1);
      do_read(A_OPEN);
      chk(err == 0, "R2 err clear", err, 0);
      do_read(A_CLOSE);
      count_to_cs_high(j);
      chk(last_bits == 0, "R2 count restart", last_bits, 0);
   endtask

   task automatic t_coincide();
      int j;
      do_read(A_OPEN);
      @(negedge clk);
      rd_stb = 1'b1; rd_addr = A_CLOSE;
      wr_stb = 1'b1; wr_addr = A_DATA; wr_data = 8'h80;
      @(negedge clk);
      rd_stb = 1'b0; wr_stb = 1'b0;
      chk(busy == 1, "R7 bit taken", busy, 1);
      count_to_cs_high(j);
      chk(j == 4 * H + 1, "R7 close deferred", j, 4 * H + 1);
      chk(last_bits == 1, "R7 count", last_bits, 1);
   endtask

   task automatic t_idle();
      int c0;
      logic [5:0] l0;
      c0 = mon_cnt; l0 = last_bits;
      do_write(8'h80);
      do_read(A_CLOSE);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(cs_n == 1 && busy == 0 && sclk == 0, "R8 quiet",
             {cs_n, busy, sclk}, 3'b100);
      end
      chk(mon_cnt == c0, "R8 no pulse", mon_cnt, c0);
      chk(last_bits == l0, "R8 count kept", last_bits, l0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      send_frame(A_OPEN, 64'hA007, 16, "pwr0");
      send_frame(A_OPEN, 64'hA240, 16, "pwr1");
      send_frame(A_OPEN, 64'hA30D, 16, "pwr2");
      send_frame(A_OPEN, 64'hA103, 16, "pwr3");
      send_frame(A_OPEN, 64'hA38D, 16, "mute");
      send_frame(A_OPEN, 64'hA24D, 16, "hi_rate");
      send_frame(A_OPEN, 64'hA600 + 64'h8F, 16, "play_l");
      send_frame(A_OPEN, 64'hA700 + 64'hFF, 16, "play_r");
      send_frame(A_DATA, {32'h0, 8'h3C, 8'h3C, 8'h91, 8'h07}, 32, "gain");
      t_bit_shape();
      t_drop();
      t_coincide();
      t_idle();
      send_frame(A_DATA, 64'h1_5A5A_C3C3, 33, "sat");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule